// File: doc/BRIEF.md
# Sleep and Idle power-mode controller

This block moves a small processor subsystem between a running state and two low-power states. The CPU asks for a power-save transition with a request strobe and a one-bit mode operand. A mode of 1 selects Sleep, where the system oscillator is stopped and both the CPU and the clocked peripherals halt. A mode of 0 selects Idle, where only the CPU clock stops and the peripherals keep running. The controller drives the clock-gating enables, the main oscillator enable, the enable of the low-power clock that feeds the watchdog, a watchdog clear pulse and the enable of the clock-failure monitor.

Wake-up comes from any pending interrupt whose own enable bit is set, or from a watchdog time-out. An interrupt that is pending but masked has no effect. When leaving Sleep, the controller turns the oscillator back on and holds the CPU stopped until the oscillator reports ready. The controller also keeps the clock-source select. On Sleep entry it saves the current select and parks the output on a low-power code. On wake it puts the saved value back. A status pair records whether the last wake was from Sleep or from Idle, and software can clear it.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the controller is running: CPU clock, peripheral clock, oscillator, low-power clock and clock-monitor enables are all 1, the watchdog clear is 0, the clock select equals DEFAULT_SEL (1), and both wake status bits are 0.
- R2: In Run, a request with saveMode=0 (Idle) gives cpuClkEn=0 from the next cycle on, while periClkEn and oscEn stay 1.
- R3: In Run, a request with saveMode=1 (Sleep) gives cpuClkEn=0 from the next cycle on. One cycle later periClkEn=0 and oscEn=0.
- R4: wdtClr is a single-cycle pulse in the cycle right after a Sleep request, and only when wdtEnabled is 1. It is 0 in every other cycle.
- R5: In Sleep, lpClkEn equals wdtEnabled. Outside Sleep, lpClkEn is 1.
- R6: fscmEn is 0 throughout Sleep and while waiting for the oscillator after Sleep, and 1 otherwise.
- R7: The wake condition is OR-reduce(irqPend AND irqEn) OR wdtTimeout. A pending source with its enable bit 0 does not wake the controller.
- R8: In Idle, a wake condition gives cpuClkEn=1 in the next cycle.
- R9: In Sleep, a wake condition moves the controller to a wait state with oscEn=1, cpuClkEn=0 and periClkEn=0. The controller stays there while oscReady=0, and cpuClkEn returns to 1 the cycle after oscReady=1 is seen.
- R10: clkSel takes selIn on selWr only in Run. In Idle and Sleep selWr is ignored. From the cycle after a Sleep request, clkSel shows SLEEP_SEL (5). From the cycle after the Sleep wake condition, it shows the value saved at entry.
- R11: Reset during Sleep returns the controller to Run at once and sets clkSel to DEFAULT_SEL, not to the saved value.
- R12: On returning to Run, wokeValid becomes 1 and wokeSleep becomes 1 for a Sleep wake or 0 for an Idle wake. wokeClr=1 clears both bits. Reset clears both bits.
- R13: A power-save request outside Run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| saveReq | input | 1 | Power-save request strobe from the CPU |
| saveMode | input | 1 | Request operand: 1 = Sleep, 0 = Idle |
| irqPend | input | N_IRQ | Per-source interrupt pending bits |
| irqEn | input | N_IRQ | Per-source interrupt enable bits |
| wdtTimeout | input | 1 | Watchdog time-out |
| wdtEnabled | input | 1 | Configuration: watchdog enabled |
| oscReady | input | 1 | Main oscillator ready after restart |
| selWr | input | 1 | Write strobe for the clock-source select |
| selIn | input | SEL_W | New clock-source select value |
| wokeClr | input | 1 | Clears the wake status bits |
| cpuClkEn | output | 1 | CPU clock gate enable |
| periClkEn | output | 1 | Peripheral clock gate enable |
| oscEn | output | 1 | Main oscillator enable |
| lpClkEn | output | 1 | Low-power watchdog clock enable |
| wdtClr | output | 1 | Watchdog clear pulse |
| fscmEn | output | 1 | Clock-failure monitor enable |
| clkSel | output | SEL_W | Active clock-source select |
| wokeValid | output | 1 | A wake has happened since the last clear |
| wokeSleep | output | 1 | The last wake was from Sleep (1) or Idle (0) |

## Verification
The hardest case to reach is the oscillator wait after Sleep. It only exists after a full Sleep entry followed by a wake, and its length is set entirely by oscReady. The stimulus table drives the controller through entry, a masked interrupt and then a watchdog wake. It holds oscReady low for an extra row, so that the restored clock select and the still-gated CPU can both be observed before release. A separate directed sequence writes a fresh select, goes into Sleep and asserts reset there, which shows that reset wins over the saved value.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    PS_RUN   = 3'd0,
    PS_IDLE  = 3'd1,
    PS_PREP  = 3'd2,
    PS_SLEEP = 3'd3,
    PS_WAIT  = 3'd4
  } pwrState_t;

  typedef struct packed {
    logic selWrite;
    logic selPark;
    logic selRestore;
    logic wokeSet;
    logic wokeSleep;
  } dpStrobe_t;
endpackage

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int SEL_W = 3,
  parameter logic [SEL_W-1:0] DEFAULT_SEL = 'd1,
  parameter logic [SEL_W-1:0] SLEEP_SEL = 'd5
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [N_IRQ-1:0] irqPend,
  input  logic [N_IRQ-1:0] irqEn,
  input  logic             wdtTimeout,
  input  logic [SEL_W-1:0] selIn,
  input  logic             wokeClr,
  output logic             wakeReq,
  output logic [SEL_W-1:0] clkSel,
  output logic             wokeValid,
  output logic             wokeSleep
);
  logic [N_IRQ-1:0] srcHit;
  logic [SEL_W-1:0] curSel;
  logic [SEL_W-1:0] savedSel;

  // per-source gating of pending by its enable
  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    assign srcHit[i] = irqPend[i] & irqEn[i];
  end

  assign wakeReq = (|srcHit) | wdtTimeout;
  assign clkSel = curSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSel   <= DEFAULT_SEL;
      savedSel <= DEFAULT_SEL;
    end else if (strobe.selPark) begin
      savedSel <= curSel;
      curSel   <= SLEEP_SEL;
    end else if (strobe.selRestore) begin
      curSel   <= savedSel;
    end else if (strobe.selWrite) begin
      curSel   <= selIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wokeValid <= 1'b0;
      wokeSleep <= 1'b0;
    end else if (strobe.wokeSet) begin
      wokeValid <= 1'b1;
      wokeSleep <= strobe.wokeSleep;
    end else if (wokeClr) begin
      wokeValid <= 1'b0;
      wokeSleep <= 1'b0;
    end
  end

  // R10: restore brings back what was saved at entry
  assert_sel_restore_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selRestore |=> curSel == $past(savedSel));
  // R10: parking shows the low-power code
  assert_sel_park_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selPark |=> curSel == SLEEP_SEL);
  // R12: a wake event always leaves the status valid
  assert_woke_set_R12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wokeSet |=> wokeValid);
endmodule

// File: rtl/pmc_control.sv
module pmc_control
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      saveReq,
  input  logic      saveMode,
  input  logic      wakeReq,
  input  logic      oscReady,
  input  logic      wdtEnabled,
  input  logic      selWr,
  output dpStrobe_t strobe,
  output logic      cpuClkEn,
  output logic      periClkEn,
  output logic      oscEn,
  output logic      lpClkEn,
  output logic      wdtClr,
  output logic      fscmEn
);
  pwrState_t state, stateNxt;
  logic clrQ;
  logic sleepAsk;

  assign sleepAsk = (state == PS_RUN) && saveReq && saveMode;

  always_comb begin
    stateNxt = state;
    unique case (state)
      PS_RUN:   if (saveReq) stateNxt = saveMode ? PS_PREP : PS_IDLE;
      PS_IDLE:  if (wakeReq) stateNxt = PS_RUN;
      PS_PREP:  stateNxt = PS_SLEEP;
      PS_SLEEP: if (wakeReq) stateNxt = PS_WAIT;
      PS_WAIT:  if (oscReady) stateNxt = PS_RUN;
      default:  stateNxt = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= PS_RUN;
      clrQ  <= 1'b0;
    end else begin
      state <= stateNxt;
      clrQ  <= sleepAsk && wdtEnabled;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.selWrite   = (state == PS_RUN) && selWr;
    strobe.selPark    = sleepAsk;
    strobe.selRestore = (state == PS_SLEEP) && wakeReq;
    strobe.wokeSet    = ((state == PS_IDLE) && wakeReq) ||
                        ((state == PS_WAIT) && oscReady);
    strobe.wokeSleep  = (state == PS_WAIT);
  end

  assign cpuClkEn  = (state == PS_RUN);
  assign periClkEn = (state == PS_RUN) || (state == PS_IDLE) || (state == PS_PREP);
  assign oscEn     = (state != PS_SLEEP);
  assign lpClkEn   = (state != PS_SLEEP) || wdtEnabled;
  assign fscmEn    = (state != PS_SLEEP) && (state != PS_WAIT);
  assign wdtClr    = clrQ;

  // R4: the clear pulse is always followed by Sleep
  assert_clr_then_sleep_R4: assert property (@(posedge clk) disable iff (!rstN)
    wdtClr |=> (state == PS_SLEEP));
  // R4: never two clear pulses in a row
  assert_clr_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    wdtClr |=> !wdtClr);
  // R8: Idle wakes straight into Run
  assert_idle_wake_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_IDLE && wakeReq) |=> cpuClkEn);
  // R7: no wake condition keeps Sleep
  assert_sleep_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_SLEEP && !wakeReq) |=> !cpuClkEn && !oscEn);
  // R9: CPU stays gated until the oscillator is ready
  assert_osc_wait_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_WAIT && !oscReady) |=> !cpuClkEn && oscEn);
  // R13: a request in Idle does not move the state
  assert_req_ignored_R13: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_IDLE && saveReq && !wakeReq) |=> (state == PS_IDLE));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int SEL_W = 3,
  parameter logic [SEL_W-1:0] DEFAULT_SEL = 'd1,
  parameter logic [SEL_W-1:0] SLEEP_SEL = 'd5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             saveReq,
  input  logic             saveMode,
  input  logic [N_IRQ-1:0] irqPend,
  input  logic [N_IRQ-1:0] irqEn,
  input  logic             wdtTimeout,
  input  logic             wdtEnabled,
  input  logic             oscReady,
  input  logic             selWr,
  input  logic [SEL_W-1:0] selIn,
  input  logic             wokeClr,
  output logic             cpuClkEn,
  output logic             periClkEn,
  output logic             oscEn,
  output logic             lpClkEn,
  output logic             wdtClr,
  output logic             fscmEn,
  output logic [SEL_W-1:0] clkSel,
  output logic             wokeValid,
  output logic             wokeSleep
);
  dpStrobe_t strobe;
  logic wakeReq;

  pmc_control u_ctrl (
    .clk(clk), .rstN(rstN), .saveReq(saveReq), .saveMode(saveMode),
    .wakeReq(wakeReq), .oscReady(oscReady), .wdtEnabled(wdtEnabled),
    .selWr(selWr), .strobe(strobe), .cpuClkEn(cpuClkEn),
    .periClkEn(periClkEn), .oscEn(oscEn), .lpClkEn(lpClkEn),
    .wdtClr(wdtClr), .fscmEn(fscmEn)
  );

  pmc_datapath #(
    .N_IRQ(N_IRQ), .SEL_W(SEL_W),
    .DEFAULT_SEL(DEFAULT_SEL), .SLEEP_SEL(SLEEP_SEL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqPend(irqPend),
    .irqEn(irqEn), .wdtTimeout(wdtTimeout), .selIn(selIn),
    .wokeClr(wokeClr), .wakeReq(wakeReq), .clkSel(clkSel),
    .wokeValid(wokeValid), .wokeSleep(wokeSleep)
  );

  // R5: with the watchdog off, Sleep leaves no clock running
  assert_lp_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!oscEn && !wdtEnabled) |-> !lpClkEn);
  // R6: the monitor is off whenever the oscillator is off
  assert_fscm_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> !fscmEn);
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic saveReq = 1'b0, saveMode = 1'b0;
  logic [7:0] irqPend = '0, irqEn = '0;
  logic wdtTimeout = 1'b0, wdtEnabled = 1'b0, oscReady = 1'b0;
  logic selWr = 1'b0, wokeClr = 1'b0;
  logic [2:0] selIn = '0;
  logic cpuClkEn, periClkEn, oscEn, lpClkEn, wdtClr, fscmEn;
  logic [2:0] clkSel;
  logic wokeValid, wokeSleep;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_ctrl dut (
    .clk(clk), .rstN(rstN), .saveReq(saveReq), .saveMode(saveMode),
    .irqPend(irqPend), .irqEn(irqEn), .wdtTimeout(wdtTimeout),
    .wdtEnabled(wdtEnabled), .oscReady(oscReady), .selWr(selWr),
    .selIn(selIn), .wokeClr(wokeClr), .cpuClkEn(cpuClkEn),
    .periClkEn(periClkEn), .oscEn(oscEn), .lpClkEn(lpClkEn),
    .wdtClr(wdtClr), .fscmEn(fscmEn), .clkSel(clkSel),
    .wokeValid(wokeValid), .wokeSleep(wokeSleep)
  );

  typedef struct packed {
    logic [3:0] req;
    logic sr, sm;
    logic [7:0] pend, en;
    logic to, we, ordy, wr;
    logic [2:0] sin;
    logic wc;
    logic [10:0] exp; // cpu peri osc lp fscm clr sel[2:0] woke sleepFlag
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    // R10 write select in Run
    '{4'd10, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 11'b111110_011_00},
    // R2 enter Idle
    '{4'd2,  1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 11'b011110_011_00},
    // R7 masked pending, R10 write ignored in Idle
    '{4'd7,  1'b0, 1'b0, 8'h04, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'd6, 1'b0, 11'b011110_011_00},
    // R13 request in Idle ignored
    '{4'd13, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 11'b011110_011_00},
    // R8 Idle wake
    '{4'd8,  1'b0, 1'b0, 8'h04, 8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 11'b111110_011_10},
    // R12 clear status
    '{4'd12, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 11'b111110_011_00},
    // R4 Sleep request with watchdog on: clear pulse, select parked
    '{4'd4,  1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 11'b011111_101_00},
    // R3 in Sleep, R5 low-power clock kept, R6 monitor off
    '{4'd3,  1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 11'b000100_101_00},
    // R7 masked source keeps Sleep
    '{4'd7,  1'b0, 1'b0, 8'h80, 8'h7F, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 11'b000100_101_00},
    // R9 watchdog wake into oscillator wait, select restored
    '{4'd9,  1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 11'b001100_011_00},
    // R9 still waiting
    '{4'd9,  1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 11'b001100_011_00},
    // R12 oscillator ready, back in Run, woke from Sleep
    '{4'd12, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 11'b111110_011_11},
    // R4 Sleep request with watchdog off: no clear
    '{4'd4,  1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 11'b011110_101_11},
    // R5 low-power clock off in Sleep
    '{4'd5,  1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 11'b000000_101_11},
    // R9 interrupt wake, osc ready already high
    '{4'd9,  1'b0, 1'b0, 8'h01, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 11'b001100_011_11},
    // R9 Run the cycle after ready is seen
    '{4'd9,  1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 11'b111110_011_11}
  };

  function automatic logic [10:0] outs();
    return {cpuClkEn, periClkEn, oscEn, lpClkEn, fscmEn, wdtClr, clkSel, wokeValid, wokeSleep};
  endfunction

  task automatic check(string tag, logic [10:0] act, logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1 reset state
    check("R1", outs(), 11'b111110_001_00);

    for (int i = 0; i < NVEC; i++) begin
      saveReq = VEC[i].sr; saveMode = VEC[i].sm;
      irqPend = VEC[i].pend; irqEn = VEC[i].en;
      wdtTimeout = VEC[i].to; wdtEnabled = VEC[i].we;
      oscReady = VEC[i].ordy; selWr = VEC[i].wr;
      selIn = VEC[i].sin; wokeClr = VEC[i].wc;
      step();
      check($sformatf("R%0d row %0d", VEC[i].req, i), outs(), VEC[i].exp);
    end

    // R11 reset in Sleep discards the saved select
    saveReq = 1'b0; irqPend = '0; irqEn = '0; wdtTimeout = 1'b0;
    selWr = 1'b1; selIn = 3'd7; wokeClr = 1'b0;
    step();
    check("R10 write 7", {8'd0, clkSel}, {8'd0, 3'd7});
    selWr = 1'b0; saveReq = 1'b1; saveMode = 1'b1;
    step();
    saveReq = 1'b0;
    step();
    check("R3 asleep", {8'd0, cpuClkEn, oscEn, periClkEn}, 11'd0);
    rstN = 1'b0;
    #1;
    check("R11 reset in Sleep", outs(), 11'b111110_001_00);
    #1 rstN = 1'b1;
    step();
    check("R11 stays Run", outs(), 11'b111110_001_00);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule